// File: doc/BRIEF.md
# Serial converter digital port model

This block is a synthesizable, cycle-based stand-in for the digital side of a 12-bit serial sampling converter. It serves as the device under test for a host controller. The host drives a convert strobe, a shift clock and a serial configuration line, all asynchronous to the model's system clock. The model resynchronises these inputs and detects their edges. It runs a conversion timer and returns the result on a serial output that has a separate output-enable.

Two parallel channel inputs take the place of the analog front end. When the convert strobe rises, the block samples either channel on its own or the difference of the two, depending on the stored input configuration. It clamps that value into the unsigned code range. The code becomes the readable result once the conversion time has elapsed.

The host writes a two-bit configuration word during each read frame. That word selects the input for the following conversion, not the current one, so the configuration always takes effect one conversion late.

Top module: `adc_port_model`

## Requirements
- R1: A rising convert strobe latches the input selected by the stored configuration. It then holds `busy` high for CONV_CYCLES system cycles. When the timer expires, the latched code becomes the readable result.
- R2: While the convert strobe is high, `sdoOe` is 0. `sleeping` is 1 exactly when the strobe is high and no conversion is running.
- R3: A falling convert strobe sets `sdoOe` and presents result bit 11 (MSB) on `sdoData`. Each later falling shift-clock edge moves to the next lower bit.
- R4: Once bit 0 has been shifted out, further falling shift-clock edges with the strobe low put 0 on `sdoData` indefinitely.
- R5: The first two `sdiIn` bits sampled on rising shift-clock edges after the strobe falls form the configuration word, first bit then second bit. Every later `sdiIn` bit in the same frame is ignored.
- R6: Configuration encoding, written {first,second}: 10 selects chanA alone, 11 selects chanB alone, 00 selects chanA minus chanB, and 01 selects chanB minus chanA. A new word applies to the next conversion, not to the one whose result is being read.
- R7: Codes are straight binary from 0 to 4095. A negative difference gives 0, and any value of 4095 or more gives 4095.
- R8: If the strobe falls while `busy` is 1, `violation` goes to 1 and the conversion is abandoned. `sdoData` then carries the previous result. `violation` clears on the next rising strobe.
- R9: After reset the configuration is 10 (chanA alone). It stays so until the first configuration word arrives.
- R10: After reset, `sdoOe`, `busy`, `sleeping` and `violation` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convIn | input | 1 | Convert strobe from host (asynchronous) |
| sckIn | input | 1 | Shift clock from host (asynchronous) |
| sdiIn | input | 1 | Serial configuration input |
| chanA | input | DATA_W+1 | Stimulus value for channel A |
| chanB | input | DATA_W+1 | Stimulus value for channel B |
| sdoData | output | 1 | Serial result bit |
| sdoOe | output | 1 | Output enable for sdoData (0 means high impedance) |
| busy | output | 1 | Conversion timer running |
| sleeping | output | 1 | Strobe high with conversion finished |
| violation | output | 1 | Strobe fell before conversion completed |

## Verification
A wrong configuration state does not show in the frame that wrote it. It shows one frame later, as a code taken from the wrong channel or with the wrong sign. For that reason the stimulus chains frames and sets each frame's expected code from the word sent in the frame before. A wrong shift-register state shows within one shift-clock period, as a misplaced bit or a nonzero tail after bit 0. A wrong timer state shows at the next strobe fall, either as a missing `violation` or as a fresh code where the old one was expected.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  // configuration word {first, second}
  localparam logic [1:0] CFG_SOLO_A = 2'b10;
  localparam logic [1:0] CFG_SOLO_B = 2'b11;
  localparam logic [1:0] CFG_A_MINUS_B = 2'b00;
  localparam logic [1:0] CFG_B_MINUS_A = 2'b01;

  typedef struct packed {
    logic sampleStb;   // latch selected input
    logic commitStb;   // conversion done, publish code
    logic loadStb;     // frame start, load shifter
    logic shiftStb;    // next lower bit
    logic cfgCapStb;   // capture one configuration bit
    logic cfgIdx;      // 0 = first bit, 1 = second bit
  } ctrlStrobes_t;

endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= asyncIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  localparam int CNT_W = $clog2(CONV_CYCLES + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         convS,
  input  logic         sckS,
  output ctrlStrobes_t strb,
  output logic         sdoOe,
  output logic         busy,
  output logic         sleeping,
  output logic         violation
);
  logic convPrev, sckPrev;
  logic [CNT_W-1:0] cnt;
  logic [1:0] cfgCnt;
  logic convRise, convFall, sckRise, sckFall;

  assign convRise = convS & ~convPrev;
  assign convFall = ~convS & convPrev;
  assign sckRise  = sckS & ~sckPrev;
  assign sckFall  = ~sckS & sckPrev;
  assign busy     = (cnt != '0);
  assign sleeping = convPrev & ~busy;

  always_comb begin
    strb.sampleStb = convRise;
    strb.commitStb = (cnt == CNT_W'(1)) & ~convFall & ~convRise;
    strb.loadStb   = convFall;
    strb.shiftStb  = sckFall & sdoOe & ~convFall;
    strb.cfgCapStb = sckRise & sdoOe & ~convFall & (cfgCnt < 2'd2);
    strb.cfgIdx    = cfgCnt[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convPrev  <= 1'b0;
      sckPrev   <= 1'b0;
      cnt       <= '0;
      violation <= 1'b0;
      sdoOe     <= 1'b0;
      cfgCnt    <= 2'd0;
    end else begin
      convPrev <= convS;
      sckPrev  <= sckS;
      if (convRise) begin
        cnt       <= CNT_W'(CONV_CYCLES);
        violation <= 1'b0;
        sdoOe     <= 1'b0;
      end else if (convFall) begin
        sdoOe  <= 1'b1;
        cfgCnt <= 2'd0;
        if (busy) begin
          violation <= 1'b1;
          cnt       <= '0;
        end
      end else begin
        if (busy) cnt <= cnt - CNT_W'(1);
        if (strb.cfgCapStb) cfgCnt <= cfgCnt + 2'd1;
      end
    end
  end

  a_r1_busy_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    convRise |=> busy);
  a_r2_oe_off_high: assert property (@(posedge clk) disable iff (!rst_n)
    convPrev |-> !sdoOe);
  a_r8_flag_on_early_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (convFall && busy) |=> violation);
  a_r8_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    convRise |=> !violation);
endmodule

// File: rtl/adc_port_dp.sv
module adc_port_dp
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int IN_W  = DATA_W + 1,
  localparam int SUM_W = IN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strb,
  input  logic             sdiS,
  input  logic [IN_W-1:0]  chanA,
  input  logic [IN_W-1:0]  chanB,
  output logic             sdoData
);
  localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((1 << DATA_W) - 1);

  logic [1:0] cfgReg;
  logic cfgFirst;
  logic [DATA_W-1:0] sampleReg, resultReg, shiftReg, selCode;
  logic signed [SUM_W-1:0] rawVal;

  always_comb begin
    unique case (cfgReg)
      CFG_SOLO_A:    rawVal = $signed({1'b0, chanA});
      CFG_SOLO_B:    rawVal = $signed({1'b0, chanB});
      CFG_A_MINUS_B: rawVal = $signed({1'b0, chanA}) - $signed({1'b0, chanB});
      default:       rawVal = $signed({1'b0, chanB}) - $signed({1'b0, chanA});
    endcase
    if (rawVal < 0)             selCode = '0;
    else if (rawVal > CODE_MAX) selCode = '1;
    else                        selCode = rawVal[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgReg    <= CFG_SOLO_A;
      cfgFirst  <= 1'b0;
      sampleReg <= '0;
      resultReg <= '0;
      shiftReg  <= '0;
    end else begin
      if (strb.cfgCapStb) begin
        if (!strb.cfgIdx) cfgFirst <= sdiS;
        else              cfgReg   <= {cfgFirst, sdiS};
      end
      if (strb.sampleStb) sampleReg <= selCode;
      if (strb.commitStb) resultReg <= sampleReg;
      if (strb.loadStb)       shiftReg <= resultReg;
      else if (strb.shiftStb) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  assign sdoData = shiftReg[DATA_W-1];

  a_r3_msb_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadStb |=> sdoData == $past(resultReg[DATA_W-1]));
  a_r5_cfg_only_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.cfgCapStb |=> $stable(cfgReg));
endmodule

// File: rtl/adc_port_model.sv
module adc_port_model
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2,
  localparam int IN_W = DATA_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            convIn,
  input  logic            sckIn,
  input  logic            sdiIn,
  input  logic [IN_W-1:0] chanA,
  input  logic [IN_W-1:0] chanB,
  output logic            sdoData,
  output logic            sdoOe,
  output logic            busy,
  output logic            sleeping,
  output logic            violation
);
  logic [2:0] syncVec;
  ctrlStrobes_t strb;

  adc_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({sdiIn, sckIn, convIn}), .syncOut(syncVec));

  adc_port_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .convS(syncVec[0]), .sckS(syncVec[1]),
    .strb(strb), .sdoOe(sdoOe), .busy(busy), .sleeping(sleeping),
    .violation(violation));

  adc_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sdiS(syncVec[2]),
    .chanA(chanA), .chanB(chanB), .sdoData(sdoData));
endmodule

// File: tb/adc_port_model_bench.sv
module adc_port_model_bench;
  localparam int DATA_W = 12;
  localparam int CONV_CYCLES = 20;
  localparam int IN_W = DATA_W + 1;
  localparam int NVEC = 9;
  localparam int HALF = 5;

  // stimulus: chanA, chanB, word sent in this frame, expected code of this frame
  localparam int VA[NVEC]  = '{100, 300, 3000, 500, 500, 5000, 7, 8000, 2730};
  localparam int VB[NVEC]  = '{200, 1234, 1000, 1700, 1700, 0, 4095, 100, 0};
  localparam int VW[NVEC]  = '{3, 0, 1, 0, 2, 3, 0, 2, 2};
  localparam int VE[NVEC]  = '{100, 1234, 2000, 1200, 0, 4095, 4095, 4095, 2730};

  logic clk = 0, rst_n = 0;
  logic convIn = 0, sckIn = 0, sdiIn = 0;
  logic [IN_W-1:0] chanA = '0, chanB = '0;
  logic sdoData, sdoOe, busy, sleeping, violation;
  int nTests = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_port_model #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_adc_port_model (
    .clk(clk), .rst_n(rst_n), .convIn(convIn), .sckIn(sckIn), .sdiIn(sdiIn),
    .chanA(chanA), .chanB(chanB), .sdoData(sdoData), .sdoOe(sdoOe),
    .busy(busy), .sleeping(sleeping), .violation(violation));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startConv(input int a, input int b);
    chanA = IN_W'(a); chanB = IN_W'(b);
    convIn = 1;
    waitc(6);
    check(busy == 1, "R1 busy during conversion", busy, 1);
    check(sdoOe == 0, "R2 output off while strobe high", sdoOe, 0);
  endtask

  // reads a frame, sending word w, returns the code
  task automatic readFrame(input int w, output int code);
    code = 0;
    convIn = 0;
    waitc(HALF);
    check(sdoOe == 1, "R3 output enabled after fall", sdoOe, 1);
    check(sleeping == 0, "R2 not sleeping with strobe low", sleeping, 0);
    for (int i = 0; i < DATA_W; i++) begin
      code = (code << 1) | int'(sdoData);
      sdiIn = (i == 0) ? w[1] : (i == 1) ? w[0] : ~w[1];  // later bits must be ignored (R5)
      sckIn = 1; waitc(HALF);
      sckIn = 0; waitc(HALF);
    end
    for (int k = 0; k < 3; k++) begin
      check(sdoData == 0, "R4 zero fill after last bit", sdoData, 0);
      sckIn = 1; waitc(HALF);
      sckIn = 0; waitc(HALF);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++; nTests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int code;
    waitc(3);
    rst_n = 1;
    waitc(2);
    check(sdoOe == 0, "R10 reset sdoOe", sdoOe, 0);
    check(busy == 0, "R10 reset busy", busy, 0);
    check(sleeping == 0, "R10 reset sleeping", sleeping, 0);
    check(violation == 0, "R10 reset violation", violation, 0);

    // chained frames: each word selects input of the following conversion (R6, R9 first entry)
    for (int v = 0; v < NVEC; v++) begin
      startConv(VA[v], VB[v]);
      waitc(CONV_CYCLES + 4);
      check(busy == 0, "R1 busy ends", busy, 0);
      check(sleeping == 1, "R2 sleeping after conversion", sleeping, 1);
      readFrame(VW[v], code);
      check(code == VE[v], "R6 R7 R9 code from configured input", code, VE[v]);
      check(violation == 0, "R8 no flag on full conversion", violation, 0);
    end

    // early fall: flag, previous result (2730) returned
    startConv(1, 0);
    readFrame(2, code);
    check(violation == 1, "R8 flag on early fall", violation, 1);
    check(code == 2730, "R8 previous result kept", code, 2730);
    startConv(1, 0);
    check(violation == 0, "R8 flag cleared on rise", violation, 0);
    waitc(CONV_CYCLES + 4);
    readFrame(2, code);
    check(code == 1, "R1 new code after full conversion", code, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule